// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block runs the column phase of an SDRAM read or write burst on the controller side. When a request is accepted it takes the starting column, the direction and the current mode word. From then on it produces, one cycle at a time, the column address of every beat of the burst. The beat order follows the programmed length and ordering. For writes it raises the bus-drive control and the per-byte write enables. For reads it delays a capture strobe so that it lines up with the programmed CAS latency. Read byte masks are applied with the two-cycle lag that the memory uses.

Page-length bursts keep running and wrap at the top of the column space until a stop request arrives. A new request that arrives during a burst takes over at once. Read beats that were already issued still come out of the capture pipeline. The command pins themselves are driven by a separate decoder from the column stream, and the data width is a parameter.

Top module: `sdr_burst_seq`

## Requirements
- R1: With mode bits [6:4] equal to 010 the read latency is 2; any other code gives latency 3. For read beat k, `rd_valid` is high in the cycle after the (latency+k)-th clock edge that follows the edge at which the request was sampled.
- R2: Mode bits [2:0] select the length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Codes 100, 101 and 110 give a single beat. Beat k occupies the cycle after the k-th edge following the request edge, and `col_valid` stays high for exactly that many cycles.
- R3: When mode bit 3 is 0, the low log2(length) bits of the column count upward from the start modulo the length, and the upper bits keep their start value.
- R4: When mode bit 3 is 1, the low log2(length) bits of beat k equal the start's low bits XOR k, and the upper bits keep their start value.
- R5: Length code 111 is a page burst. Its order is always sequential whatever bit 3 says, and it runs without end, going from the all-ones column to column 0.
- R6: A `burst_stop` sampled at an edge with no request ends the burst, and no column follows that edge. Read beats issued before the stop are still delivered through `rd_valid`.
- R7: When mode bit 9 is 1, a write burst has a single beat, while reads keep the programmed length.
- R8: `dq_oe` is high exactly in the write beat cycles. In those cycles `wr_byte_en` is the inverse of `dqm` in the same cycle; at all other times it is zero.
- R9: While `rd_valid` is high, `rd_byte_en` is the inverse of the `dqm` value sampled two edges before the edge that opened the current cycle. At all other times it is zero, which leaves the bus released.
- R10: A request sampled during a burst drops the remaining beats of the old burst and starts the new one at beat 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a burst at this edge |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_col | input | COL_W | Starting column |
| burst_stop | input | 1 | End the running burst |
| mode_word | input | 12 | Mode settings: [2:0] length, [3] order, [6:4] latency, [9] single-beat writes |
| dqm | input | DATA_W/8 | Per-byte mask |
| col_valid | output | 1 | A beat is in progress this cycle |
| col_addr | output | COL_W | Column of the current beat |
| col_is_write | output | 1 | Current beat belongs to a write |
| dq_oe | output | 1 | Controller drives the data bus |
| wr_byte_en | output | DATA_W/8 | Write byte enables |
| rd_valid | output | 1 | Read data capture strobe |
| rd_byte_en | output | DATA_W/8 | Bytes actually returned by the memory |

## Verification
The latency assertion assumes that `mode_word` does not change while a burst runs or while read beats are still in the capture pipeline. The bench therefore changes the mode only at the start of a request, and only after several idle cycles that let the previous reads drain. The checks assume that the request, the stop and `dqm` are driven cleanly for whole cycles. The bench changes them only on the falling edge and samples the outputs late in the cycle.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    localparam logic [2:0] LAT_TWO_CODE = 3'b010;

    typedef struct packed {
        logic       page;
        logic       ilv;
        logic       lat3;
        logic       wr_single;
        logic [1:0] len_log2;
    } seq_cfg_t;

    function automatic seq_cfg_t decode_mode(input logic [11:0] mw);
        seq_cfg_t c;
        c           = '0;
        c.lat3      = (mw[6:4] != LAT_TWO_CODE);
        c.wr_single = mw[9];
        case (len_code_e'(mw[2:0]))
            LEN_ONE:   c.len_log2 = 2'd0;
            LEN_TWO:   c.len_log2 = 2'd1;
            LEN_FOUR:  c.len_log2 = 2'd2;
            LEN_EIGHT: c.len_log2 = 2'd3;
            LEN_PAGE:  c.page     = 1'b1;
            default:   c.len_log2 = 2'd0;
        endcase
        c.ilv = mw[3] & ~c.page;
        return c;
    endfunction

endpackage

// File: rtl/sdr_mode_decode.sv
module sdr_mode_decode
    import sdr_seq_pkg::*;
(
    input  logic [11:0] mode_word,
    output seq_cfg_t    cfg
);
    logic unused_mode_bits;
    assign unused_mode_bits = ^{mode_word[11:10], mode_word[8:7]};
    assign cfg = decode_mode(mode_word);
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_wr,
    input  logic [COL_W-1:0] load_col,
    input  seq_cfg_t         cfg,
    input  logic             stop,
    output logic             active,
    output logic             beat_wr,
    output logic [COL_W-1:0] col
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    logic             act_q, wr_q, page_q, ilv_q;
    logic [COL_W-1:0] start_q, cnt_q, lmask_q;
    logic             single_now, page_now;
    logic [COL_W-1:0] lmask_now, offs;

    // single-beat writes override both finite and page lengths
    assign single_now = load_wr & cfg.wr_single;
    assign page_now   = cfg.page & ~single_now;
    assign lmask_now  = page_now   ? ALL_ONES :
                        single_now ? '0 :
                        ~(ALL_ONES << cfg.len_log2);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            page_q  <= 1'b0;
            ilv_q   <= 1'b0;
            start_q <= '0;
            cnt_q   <= '0;
            lmask_q <= '0;
        end else if (load) begin
            act_q   <= 1'b1;
            wr_q    <= load_wr;
            page_q  <= page_now;
            ilv_q   <= cfg.ilv & ~page_now;
            start_q <= load_col;
            cnt_q   <= '0;
            lmask_q <= lmask_now;
        end else if (stop) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            if (!page_q && (cnt_q == lmask_q)) act_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign offs    = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
    assign col     = (start_q & ~lmask_q) | (offs & lmask_q);
    assign active  = act_q;
    assign beat_wr = wr_q;

    // R2: a finite burst never counts past its length
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (act_q && !page_q) |-> ((cnt_q & ~lmask_q) == '0));

    // R5: page bursts roll over from the top column to zero
    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (act_q && page_q && !load && !stop && (col == ALL_ONES)) |=> (act_q && (col == '0)));

    // R6: a stop with no new request leaves no beat behind
    assert_stop_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> !act_q);

    // R7: a single-beat write lasts one cycle
    assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
        (load && load_wr && cfg.wr_single) |=> (act_q ##1 (!act_q || $past(load))));
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_in,
    input  logic          lat3,
    input  logic [NB-1:0] dqm,
    output logic          rd_valid,
    output logic [NB-1:0] rd_byte_en
);
    localparam int MAX_LAT = 3;
    localparam int MASK_LAG = 3;

    logic [MAX_LAT-1:0] dly_q;
    logic [NB-1:0]      mq [MASK_LAG];

    always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= {dly_q[MAX_LAT-2:0], beat_in};
    end

    for (genvar s = 0; s < MASK_LAG; s++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)         mq[s] <= '0;
            else if (s == 0) mq[s] <= dqm;
            else             mq[s] <= mq[(s == 0) ? 0 : s-1];
        end
    end

    assign rd_valid   = lat3 ? dly_q[2] : dly_q[1];
    assign rd_byte_en = rd_valid ? ~mq[MASK_LAG-1] : '0;

    // R1: strobe trails the issued read beat by the selected latency
    assert_lat2_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !lat3) |-> $past(beat_in, 2));
    assert_lat3_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && lat3) |-> $past(beat_in, 3));
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [COL_W-1:0]      req_col,
    input  logic                  burst_stop,
    input  logic [11:0]           mode_word,
    input  logic [DATA_W/8-1:0]   dqm,
    output logic                  col_valid,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_is_write,
    output logic                  dq_oe,
    output logic [DATA_W/8-1:0]   wr_byte_en,
    output logic                  rd_valid,
    output logic [DATA_W/8-1:0]   rd_byte_en
);
    localparam int NB = DATA_W / 8;

    seq_cfg_t cfg;
    logic     act, bwr;

    sdr_mode_decode u_mode (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_cols (
        .clk      (clk),
        .rst      (rst),
        .load     (req_valid),
        .load_wr  (req_write),
        .load_col (req_col),
        .cfg      (cfg),
        .stop     (burst_stop),
        .active   (act),
        .beat_wr  (bwr),
        .col      (col_addr)
    );

    sdr_rd_pipe #(.NB(NB)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .beat_in    (act & ~bwr),
        .lat3       (cfg.lat3),
        .dqm        (dqm),
        .rd_valid   (rd_valid),
        .rd_byte_en (rd_byte_en)
    );

    assign col_valid    = act;
    assign col_is_write = act & bwr;
    assign dq_oe        = act & bwr;
    assign wr_byte_en   = dq_oe ? ~dqm : '0;
endmodule

// File: tb/test_sdr_burst_seq.sv
`timescale 1ns/100ps
module test_sdr_burst_seq;
    localparam int COL_W = 10;
    localparam int NB    = 8;

    logic clk = 1'b0;
    logic rst, req_valid, req_write, burst_stop;
    logic [COL_W-1:0] req_col;
    logic [11:0] mode_word;
    logic [NB-1:0] dqm;
    logic col_valid, col_is_write, dq_oe, rd_valid;
    logic [COL_W-1:0] col_addr;
    logic [NB-1:0] wr_byte_en, rd_byte_en;

    always #2.5 clk = ~clk;

    sdr_burst_seq #(.COL_W(COL_W), .DATA_W(NB*8)) i_sdr_burst_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_col(req_col), .burst_stop(burst_stop), .mode_word(mode_word), .dqm(dqm),
        .col_valid(col_valid), .col_addr(col_addr), .col_is_write(col_is_write),
        .dq_oe(dq_oe), .wr_byte_en(wr_byte_en), .rd_valid(rd_valid), .rd_byte_en(rd_byte_en)
    );

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             wr;
        logic [NB-1:0]    be;
        logic [7:0]       tag;
    } col_item_t;

    typedef struct packed {
        logic [NB-1:0] be;
        logic [7:0]    tag;
    } rd_item_t;

    col_item_t col_q[$];
    rd_item_t  rd_q[$];
    logic [NB-1:0] bmask [32];
    int checks = 0, fails = 0;
    bit mon_en = 0, done = 0;

    task automatic note(input bit ok, input int tag, input string what, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
        end
    endtask

    function automatic int exp_col(input int start, input int k, input int l2, input bit ilv, input bit page);
        int len, base, lo;
        if (page) return (start + k) % (1 << COL_W);
        len  = 1 << l2;
        lo   = start % len;
        base = start - lo;
        if (ilv) return base + (lo ^ k);
        return base + ((lo + k) % len);
    endfunction

    function automatic logic [11:0] mk_mode(input int lcode, input bit ilv, input int lat, input bit ws);
        logic [2:0] lc, lt;
        lc = 3'(lcode);
        lt = 3'(lat);
        return {2'b00, ws, 2'b00, lt, ilv, lc};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; burst_stop = 0; dqm = '0;
        end
    endtask

    // driver: pushes the expected beats, then drives request, stop and mask
    task automatic issue(input bit wr, input int col, input int beats, input int lat,
                         input int cycles, input int stop_at, input int l2,
                         input bit ilv, input bit page, input logic [11:0] mw, input int tag);
        for (int k = 0; k < beats; k++) begin
            col_item_t ci;
            rd_item_t  ri;
            ci.col = COL_W'(exp_col(col, k, l2, ilv, page));
            ci.wr  = wr;
            ci.be  = wr ? ~bmask[k] : '0;
            ci.tag = 8'(tag);
            col_q.push_back(ci);
            if (!wr) begin
                ri.be  = ~bmask[k];
                ri.tag = 8'(tag);
                rd_q.push_back(ri);
            end
        end
        for (int j = 0; j < cycles; j++) begin
            int k;
            @(negedge clk);
            req_valid  = (j == 0);
            req_write  = wr;
            req_col    = COL_W'(col);
            mode_word  = mw;
            burst_stop = (j == stop_at);
            k = wr ? j - 1 : j - lat + 2;
            dqm = (k >= 0 && k < beats) ? bmask[k] : '0;
        end
    endtask

    task automatic clear_masks();
        for (int i = 0; i < 32; i++) bmask[i] = '0;
    endtask

    // monitor: pops expected beats and compares late in each cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_en && !done) begin
                if (col_valid) begin
                    if (col_q.size() == 0) begin
                        note(0, 2, "unexpected column", int'(col_addr), 0);
                    end else begin
                        col_item_t e;
                        e = col_q.pop_front();
                        note(col_addr == e.col, int'(e.tag), "column", int'(col_addr), int'(e.col));
                        note(col_is_write == e.wr, int'(e.tag), "direction", int'(col_is_write), int'(e.wr));
                        note(dq_oe == e.wr, 8, "bus drive", int'(dq_oe), int'(e.wr));
                        note(wr_byte_en == e.be, 8, "write enables", int'(wr_byte_en), int'(e.be));
                    end
                end else begin
                    note(!dq_oe && wr_byte_en == '0, 8, "idle drive", int'({dq_oe, wr_byte_en}), 0);
                end
                if (rd_valid) begin
                    if (rd_q.size() == 0) begin
                        note(0, 1, "unexpected read strobe", 1, 0);
                    end else begin
                        rd_item_t r;
                        r = rd_q.pop_front();
                        note(rd_byte_en == r.be, 9, "read enables", int'(rd_byte_en), int'(r.be));
                    end
                end else begin
                    note(rd_byte_en == '0, 9, "read enables idle", int'(rd_byte_en), 0);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R0 watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_write = 0; burst_stop = 0;
        req_col = '0; mode_word = '0; dqm = '0;
        clear_masks();
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // reset state (R2, R8, R1)
        note(!col_valid, 2, "reset col_valid", int'(col_valid), 0);
        note(!dq_oe, 8, "reset dq_oe", int'(dq_oe), 0);
        note(!rd_valid, 1, "reset rd_valid", int'(rd_valid), 0);
        mon_en = 1;

        // R1 R3: read, 4 beats, sequential, latency 2, start 5 -> 5,6,7,4
        issue(0, 5, 4, 2, 6, -1, 2, 0, 0, mk_mode(2, 0, 2, 0), 3);
        idle(6);
        // R1 R4: latency 3, interleaved, start 6 -> 6,7,4,5
        issue(0, 6, 4, 3, 6, -1, 2, 1, 0, mk_mode(2, 1, 3, 0), 4);
        idle(6);
        // R4: 8 beats interleaved from 45 -> 45,44,47,46,41,40,43,42
        issue(0, 45, 8, 2, 9, -1, 3, 1, 0, mk_mode(3, 1, 2, 0), 4);
        idle(6);
        // R8 R3: write 8 beats from 19 with a walking mask
        for (int i = 0; i < 8; i++) bmask[i] = 8'h01 << i;
        issue(1, 19, 8, 2, 10, -1, 3, 0, 0, mk_mode(3, 0, 2, 0), 8);
        idle(6);
        clear_masks();
        // R7: single-beat writes, reads keep length 8
        issue(1, 300, 1, 2, 3, -1, 0, 0, 0, mk_mode(3, 0, 2, 1), 7);
        idle(6);
        issue(0, 3, 8, 2, 9, -1, 3, 0, 0, mk_mode(3, 0, 2, 1), 7);
        idle(6);
        // R2: reserved length code 100 gives one beat
        issue(0, 77, 1, 3, 3, -1, 0, 0, 0, mk_mode(4, 0, 3, 0), 2);
        idle(6);
        // R2 R3: two beats from 9 -> 9,8 ; one-beat write at 700
        issue(0, 9, 2, 2, 3, -1, 1, 0, 0, mk_mode(1, 0, 2, 0), 2);
        idle(6);
        issue(1, 700, 1, 2, 2, -1, 0, 0, 0, mk_mode(0, 0, 2, 0), 2);
        idle(6);
        // R5 R6: page read from 1020 with order bit set, stopped after 6 beats
        issue(0, 1020, 6, 3, 7, 6, 0, 0, 1, mk_mode(7, 1, 3, 0), 5);
        idle(8);
        // R9: read mask lag, latency 3
        bmask[1] = 8'hF0; bmask[3] = 8'hFF; bmask[2] = 8'h81;
        issue(0, 64, 4, 3, 7, -1, 2, 0, 0, mk_mode(2, 0, 3, 0), 9);
        idle(6);
        clear_masks();
        // R10: read of 8 from 16 cut after 3 beats by a 4-beat write at 100
        issue(0, 16, 3, 2, 3, -1, 3, 0, 0, mk_mode(3, 0, 2, 0), 10);
        issue(1, 100, 4, 2, 5, -1, 2, 0, 0, mk_mode(2, 0, 2, 0), 10);
        idle(8);

        note(col_q.size() == 0, 2, "columns left over", col_q.size(), 0);
        note(rd_q.size() == 0, 6, "reads left over", rd_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule